// File: doc/BRIEF.md
# Fractional master clock and frame clock generator

This block builds an audio master clock from a 32 MHz reference clock. A programmable 32-bit increment is added to a phase accumulator on every reference cycle. The accumulator's top bit is the master clock, so the master clock runs at the reference rate times the increment divided by 2^32. Fractional divisions are possible, with period jitter of one reference cycle.

In master mode the block also derives the bit clock and the word (frame) clock from the master clock. The divide from master clock to word clock is chosen from a table of nine ratios, several of which are not powers of two. The divide from master clock to bit clock follows from that ratio and the sample width. Every word-clock transition is placed on a falling bit-clock edge. Each derived clock comes with a one-cycle strobe, in the reference domain, that marks its edges for a serial engine.

Start and stop inputs control the whole generator. A separate enable lets the master clock run in slave mode, where the bit and word clocks are left to the external master. An illegal pairing of ratio and width raises an error flag and keeps the derived clocks low.

Top module: `mclk_frame_gen`

## Requirements
- R1: While reset is asserted and after its release, all clock outputs and strobes are 0. The error flag depends only on the current ratio and width codes.
- R2: start_i begins generation. stop_i halts it and has priority when both are high in the same cycle. In the cycle after stop_i is sampled, mck_o, bclk_o and wclk_o are all 0 and remain 0 until the next start.
- R3: mck_o is bit 31 of a 32-bit accumulator. The accumulator is zero when idle and adds freq_code_i at every reference edge while running, starting at the start edge. After the k-th update, mck_o equals bit 31 of (k * freq_code_i mod 2^32). The code 0x20000000 gives a period of 8 reference cycles, and 0x50000000 divides by 3.2.
- R4: With mck_en_i = 0 the accumulator does not advance. mck_o, bclk_o and wclk_o stay 0 even after a start.
- R5: ratio_sel_i codes 0..8 select master-to-word ratios of 32, 48, 64, 96, 128, 192, 256, 384 and 512. width_sel_i codes 0, 1 and 2 select sample widths of 8, 16 and 24 bits. One word-clock period lasts the selected ratio in master-clock periods.
- R6: cfg_err_o is 1 when the ratio code is above 8, when the width code is 3, or when the ratio is not a whole multiple (at least 1) of twice the width. While it is 1, bclk_o and wclk_o are 0 from the following cycle.
- R7: A bit-clock period lasts D = ratio/(2*width) master-clock periods. Each half of the bit clock lasts exactly D master-clock edges, counting rising and falling edges.
- R8: Each word-clock half period holds exactly width bit-clock periods. Every wclk_o transition happens in the same cycle as a bclk_o falling edge.
- R9: After start, bclk_o and wclk_o begin low. wclk_o first toggles, rising, on the width-th bit-clock falling edge. Derived clock changes follow the causing master-clock edge by one reference cycle, so with code 0x20000000 the first wclk_o rise shows after reference edge 4*ratio+1, where the start edge is edge 1.
- R10: With master_i = 0 the master clock still runs when enabled, and bclk_o and wclk_o stay 0.
- R11: mck_rise_o, bclk_rise_o, bclk_fall_o and wclk_tgl_o are high for one cycle, in exactly the cycle in which the matching output first shows its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start generation (one-cycle pulse) |
| stop_i | input | 1 | Stop generation (one-cycle pulse) |
| mck_en_i | input | 1 | Master clock generator enable |
| master_i | input | 1 | 1: derive bit and word clocks; 0: slave mode |
| freq_code_i | input | 32 | Accumulator increment |
| ratio_sel_i | input | 4 | Master-to-word ratio code |
| width_sel_i | input | 2 | Sample width code |
| mck_o | output | 1 | Master clock |
| mck_rise_o | output | 1 | Master clock rising-edge strobe |
| bclk_o | output | 1 | Bit clock |
| bclk_rise_o | output | 1 | Bit clock rising-edge strobe |
| bclk_fall_o | output | 1 | Bit clock falling-edge strobe |
| wclk_o | output | 1 | Word clock |
| wclk_tgl_o | output | 1 | Word clock toggle strobe |
| cfg_err_o | output | 1 | Illegal ratio and width combination |

## Verification
The master clock is compared cycle by cycle against the accumulator formula for three increments. The power-of-two codes check exact division, and 0x50000000 shows whether fractional carries land on the right cycles. Frame timing is measured for three ratio and width pairs. The pair 256 with 16 has an even bit divisor. The pair 48 with 8 has an odd divisor of 3, which exposes half-period rounding. The pair 32 with 16 has a divisor of 1, where the bit clock toggles on every master edge. Illegal pairs, a stop during streaming, a simultaneous start and stop, a disabled generator and slave mode each confirm that the derived clocks stay quiet.

// File: rtl/mfg_pkg.sv
package mfg_pkg;
  localparam int ACC_W     = 32;
  localparam int RATIO_W   = 10;
  localparam int WID_LEN_W = 5;

  function automatic logic [RATIO_W-1:0] ratio_len(input logic [3:0] sel);
    case (sel)
      4'd0:    return 10'd32;
      4'd1:    return 10'd48;
      4'd2:    return 10'd64;
      4'd3:    return 10'd96;
      4'd4:    return 10'd128;
      4'd5:    return 10'd192;
      4'd6:    return 10'd256;
      4'd7:    return 10'd384;
      4'd8:    return 10'd512;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WID_LEN_W-1:0] width_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd8;
      2'd1:    return 5'd16;
      2'd2:    return 5'd24;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mfg_accum.sv
module mfg_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] step_i,
  output logic             mck_o,
  output logic             rise_o,
  output logic             edge_o
);
  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] acc_q, sum;
  logic             rise_q, edge_q;

  assign sum = acc_q + step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rise_q <= 1'b0;
      edge_q <= 1'b0;
    end else if (en_i) begin
      acc_q  <= sum;
      rise_q <= sum[MSB] & ~acc_q[MSB];
      edge_q <= sum[MSB] ^ acc_q[MSB];
    end else begin
      acc_q  <= '0;
      rise_q <= 1'b0;
      edge_q <= 1'b0;
    end
  end

  assign mck_o  = acc_q[MSB];
  assign rise_o = rise_q;
  assign edge_o = edge_q;
endmodule

// File: rtl/mfg_cfg_check.sv
module mfg_cfg_check
  import mfg_pkg::*;
#(
  parameter int DIV_MAX = 32,
  parameter int DIV_W   = $clog2(DIV_MAX + 1)
) (
  input  logic [3:0]           ratio_sel_i,
  input  logic [1:0]           width_sel_i,
  output logic [DIV_W-1:0]     div_o,
  output logic [WID_LEN_W-1:0] width_o,
  output logic                 err_o
);
  logic [RATIO_W-1:0]   rl;
  logic [WID_LEN_W-1:0] wl;
  logic [RATIO_W:0]     prod;

  assign rl      = ratio_len(ratio_sel_i);
  assign wl      = width_len(width_sel_i);
  assign width_o = wl;

  // search for an integer bit divisor k with k * 2 * width == ratio
  always_comb begin
    div_o = '0;
    prod  = '0;
    for (int k = 1; k <= DIV_MAX; k++) begin
      prod = (RATIO_W+1)'(k) * (RATIO_W+1)'({wl, 1'b0});
      if (wl != '0 && {1'b0, rl} == prod) div_o = DIV_W'(k);
    end
  end

  assign err_o = (div_o == '0);
endmodule

// File: rtl/mfg_frame_div.sv
module mfg_frame_div #(
  parameter int DIV_W = 6,
  parameter int BIT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mck_edge_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BIT_W-1:0] width_i,
  output logic             bclk_o,
  output logic             bclk_rise_o,
  output logic             bclk_fall_o,
  output logic             wclk_o,
  output logic             wclk_tgl_o
);
  logic [DIV_W-1:0] edge_cnt_q;
  logic [BIT_W-1:0] bit_cnt_q;
  logic bclk_q, wclk_q, rise_q, fall_q, tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt_q <= '0;
      bit_cnt_q  <= '0;
      bclk_q     <= 1'b0;
      wclk_q     <= 1'b0;
      rise_q     <= 1'b0;
      fall_q     <= 1'b0;
      tgl_q      <= 1'b0;
    end else if (!en_i) begin
      edge_cnt_q <= '0;
      bit_cnt_q  <= '0;
      bclk_q     <= 1'b0;
      wclk_q     <= 1'b0;
      rise_q     <= 1'b0;
      fall_q     <= 1'b0;
      tgl_q      <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      tgl_q  <= 1'b0;
      if (mck_edge_i) begin
        if (edge_cnt_q == div_i - DIV_W'(1)) begin
          edge_cnt_q <= '0;
          bclk_q     <= ~bclk_q;
          if (bclk_q) begin
            fall_q <= 1'b1;
            // word clock moves only on a completed bit
            if (bit_cnt_q == width_i - BIT_W'(1)) begin
              bit_cnt_q <= '0;
              wclk_q    <= ~wclk_q;
              tgl_q     <= 1'b1;
            end else begin
              bit_cnt_q <= bit_cnt_q + BIT_W'(1);
            end
          end else begin
            rise_q <= 1'b1;
          end
        end else begin
          edge_cnt_q <= edge_cnt_q + DIV_W'(1);
        end
      end
    end
  end

  assign bclk_o      = bclk_q;
  assign bclk_rise_o = rise_q;
  assign bclk_fall_o = fall_q;
  assign wclk_o      = wclk_q;
  assign wclk_tgl_o  = tgl_q;
endmodule

// File: rtl/mclk_frame_gen.sv
module mclk_frame_gen
  import mfg_pkg::*;
#(
  parameter int RATIO_MAX = 512,
  parameter int WIDTH_MIN = 8,
  parameter int WIDTH_MAX = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             mck_en_i,
  input  logic             master_i,
  input  logic [ACC_W-1:0] freq_code_i,
  input  logic [3:0]       ratio_sel_i,
  input  logic [1:0]       width_sel_i,
  output logic             mck_o,
  output logic             mck_rise_o,
  output logic             bclk_o,
  output logic             bclk_rise_o,
  output logic             bclk_fall_o,
  output logic             wclk_o,
  output logic             wclk_tgl_o,
  output logic             cfg_err_o
);
  localparam int DIV_MAX = RATIO_MAX / (2 * WIDTH_MIN);
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  logic                 run_q, go, mck_edge, err;
  logic [DIV_W-1:0]     div;
  logic [WID_LEN_W-1:0] wlen;

  assign go = (run_q | start_i) & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= go;
  end

  mfg_cfg_check #(.DIV_MAX(DIV_MAX), .DIV_W(DIV_W)) u_cfg (
    .ratio_sel_i (ratio_sel_i),
    .width_sel_i (width_sel_i),
    .div_o       (div),
    .width_o     (wlen),
    .err_o       (err)
  );

  mfg_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (go & mck_en_i),
    .step_i (freq_code_i),
    .mck_o  (mck_o),
    .rise_o (mck_rise_o),
    .edge_o (mck_edge)
  );

  mfg_frame_div #(.DIV_W(DIV_W), .BIT_W(WID_LEN_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (go & mck_en_i & master_i & ~err),
    .mck_edge_i  (mck_edge),
    .div_i       (div),
    .width_i     (wlen),
    .bclk_o      (bclk_o),
    .bclk_rise_o (bclk_rise_o),
    .bclk_fall_o (bclk_fall_o),
    .wclk_o      (wclk_o),
    .wclk_tgl_o  (wclk_tgl_o)
  );

  assign cfg_err_o = err;
endmodule

// File: rtl/mclk_frame_gen_chk.sv
module mclk_frame_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        stop_i,
  input logic        mck_en_i,
  input logic        master_i,
  input logic [31:0] freq_code_i,
  input logic [3:0]  ratio_sel_i,
  input logic [1:0]  width_sel_i,
  input logic        mck_o,
  input logic        mck_rise_o,
  input logic        bclk_o,
  input logic        bclk_rise_o,
  input logic        bclk_fall_o,
  input logic        wclk_o,
  input logic        wclk_tgl_o,
  input logic        cfg_err_o
);
  // R2
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!mck_o && !bclk_o && !wclk_o));

  // R4
  mck_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mck_en_i |=> !mck_o);

  // R6
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> (!bclk_o && !wclk_o));

  // R8
  wclk_on_bfall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wclk_o != $past(wclk_o)) |-> ($past(bclk_o) && !bclk_o));

  // R10
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (!bclk_o && !wclk_o));

  // R11
  bclk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_rise_o |-> (bclk_o && !$past(bclk_o)));

  // R11
  mck_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mck_rise_o |-> (mck_o && !$past(mck_o)));
endmodule

bind mclk_frame_gen mclk_frame_gen_chk u_chk (.*);

// File: tb/sim_mclk_frame_gen.sv
`timescale 1ns/1ps
module sim_mclk_frame_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic        mck_en_i = 1'b1, master_i = 1'b1;
  logic [31:0] freq_code_i = 32'h2000_0000;
  logic [3:0]  ratio_sel_i = 4'd6;
  logic [1:0]  width_sel_i = 2'd1;
  logic mck_o, mck_rise_o, bclk_o, bclk_rise_o, bclk_fall_o, wclk_o, wclk_tgl_o, cfg_err_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  mclk_frame_gen u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk_i) stop_i = 1'b1;
    @(negedge clk_i) stop_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(!mck_o && !bclk_o && !wclk_o && !mck_rise_o && !wclk_tgl_o, "R1 outputs in reset",
        {mck_o, bclk_o, wclk_o}, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!mck_o && !bclk_o && !wclk_o && !bclk_rise_o && !bclk_fall_o, "R1 idle after reset",
        {mck_o, bclk_o, wclk_o}, 0);
    chk(cfg_err_o == 1'b0, "R1 err for legal codes", cfg_err_o, 0);
  endtask

  task automatic t_mck(input logic [31:0] code, input int n);
    int bad = 0, rbad = 0;
    logic pexp = 1'b0;
    halt();
    freq_code_i = code;
    pulse_start();
    for (int k = 1; k <= n; k++) begin
      logic [63:0] p;
      p = 64'(k) * 64'(code);
      if (mck_o !== p[31]) bad++;
      if (mck_rise_o !== (p[31] & ~pexp)) rbad++;
      pexp = p[31];
      @(negedge clk_i);
    end
    chk(bad == 0, "R3 accumulator msb sequence", bad, 0);
    chk(rbad == 0, "R11 master rise strobe", rbad, 0);
  endtask

  task automatic t_frame(input logic [3:0] rc, input logic [1:0] wc, input int ratio, input int w);
    int div, cnt, cyc, rises, last_rise, per_bad, strb_bad;
    logic pb;
    div = ratio / (2 * w);
    halt();
    ratio_sel_i = rc; width_sel_i = wc; freq_code_i = 32'h2000_0000;
    pulse_start();
    cnt = 1;
    while (!wclk_o && cnt < 20000) begin
      @(negedge clk_i);
      cnt++;
    end
    chk(cnt == 4 * ratio + 1, "R9 first word toggle", cnt, 4 * ratio + 1);
    chk(bclk_fall_o && !bclk_o && wclk_tgl_o, "R8 toggle on bit fall",
        {bclk_fall_o, bclk_o, wclk_tgl_o}, 5);
    pb = bclk_o; cyc = 0; rises = 0; last_rise = -1; per_bad = 0; strb_bad = 0;
    do begin
      @(negedge clk_i);
      cyc++;
      if ((bclk_o && !pb) != bclk_rise_o) strb_bad++;
      if (bclk_o && !pb) begin
        rises++;
        if (last_rise >= 0 && cyc - last_rise != 8 * div) per_bad++;
        last_rise = cyc;
      end
      pb = bclk_o;
    end while (wclk_o && cyc < 20000);
    chk(cyc == 4 * ratio, "R5 half frame length", cyc, 4 * ratio);
    chk(rises == w, "R8 bits per half frame", rises, w);
    chk(per_bad == 0, "R7 bit clock period", per_bad, 0);
    chk(strb_bad == 0 && wclk_tgl_o && bclk_fall_o, "R11 edge strobes", strb_bad, 0);
  endtask

  task automatic t_illegal(input logic [3:0] rc, input logic [1:0] wc, input bit exp_err);
    int bad = 0;
    halt();
    ratio_sel_i = rc; width_sel_i = wc; freq_code_i = 32'h2000_0000;
    #1;
    chk(cfg_err_o == exp_err, "R6 error flag", cfg_err_o, exp_err);
    if (exp_err) begin
      pulse_start();
      repeat (600) begin
        if (bclk_o || wclk_o) bad++;
        @(negedge clk_i);
      end
      chk(bad == 0, "R6 clocks held low", bad, 0);
    end
  endtask

  task automatic t_stop();
    int bad = 0;
    halt();
    ratio_sel_i = 4'd0; width_sel_i = 2'd1;
    pulse_start();
    repeat (300) @(negedge clk_i);
    stop_i = 1'b1;
    @(negedge clk_i) stop_i = 1'b0;
    chk(!mck_o && !bclk_o && !wclk_o, "R2 low after stop", {mck_o, bclk_o, wclk_o}, 0);
    repeat (50) begin
      if (mck_o || bclk_o) bad++;
      @(negedge clk_i);
    end
    start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk_i) begin start_i = 1'b0; stop_i = 1'b0; end
    repeat (50) begin
      if (mck_o || bclk_o || wclk_o) bad++;
      @(negedge clk_i);
    end
    chk(bad == 0, "R2 stop wins and stays idle", bad, 0);
  endtask

  task automatic t_no_mck();
    int bad = 0;
    halt();
    mck_en_i = 1'b0;
    pulse_start();
    repeat (200) begin
      if (mck_o || bclk_o || wclk_o) bad++;
      @(negedge clk_i);
    end
    chk(bad == 0, "R4 generator disabled", bad, 0);
    halt();
    mck_en_i = 1'b1;
  endtask

  task automatic t_slave();
    int bad = 0, rises = 0;
    halt();
    master_i = 1'b0; freq_code_i = 32'h2000_0000;
    pulse_start();
    for (int k = 1; k <= 200; k++) begin
      if (mck_rise_o) rises++;
      if (bclk_o || wclk_o) bad++;
      @(negedge clk_i);
    end
    chk(rises == 25, "R10 master clock runs in slave", rises, 25);
    chk(bad == 0, "R10 derived clocks quiet", bad, 0);
    halt();
    master_i = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog expired act=%0d exp=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    t_mck(32'h2000_0000, 40);
    t_mck(32'h5000_0000, 40);
    t_mck(32'h0800_0000, 160);
    t_frame(4'd6, 2'd1, 256, 16);
    t_frame(4'd1, 2'd0, 48, 8);
    t_frame(4'd0, 2'd1, 32, 16);
    t_illegal(4'd0, 2'd2, 1'b1);
    t_illegal(4'd2, 2'd2, 1'b1);
    t_illegal(4'd9, 2'd1, 1'b1);
    t_illegal(4'd6, 2'd3, 1'b1);
    t_illegal(4'd5, 2'd2, 1'b0);
    t_stop();
    t_no_mck();
    t_slave();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule